// File: doc/BRIEF.md
# Intermittent Wiper Interval Sequencer

This block runs the interval wiping mode of a windscreen wiper controller. Two raw contacts feed it: the interval selector switch and the wiper park switch. Each contact passes through a short synchronizer and then a filter that must see a new level on a set number of consecutive clock cycles. The filter treats the closing and the opening edge in the same way. Once the interval switch reads closed, the block asks for the relay. The relay request stays on until the park contact has left its rest level and then come back to it, which marks one full sweep.

After a sweep, the block checks the interval switch. If the switch is still closed, the block drops the relay and holds a pause for a number of clock ticks given on an input. During that pause it raises a select line that tells an external oscillator to run at its slower interval rate. When the pause ends, the select line falls and the next sweep begins. If the switch is open when a sweep finishes, the block goes back to idle. Opening the switch partway through a sweep never shortens that sweep. For a set number of cycles after reset, the relay request is held off.

Top module: `wiper_interval_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `relay_on` and `slow_sel` are both low.
- R2: For `POR_CYCLES` clock cycles after reset is released, `relay_on` stays low whatever the inputs do.
- R3: A new raw level reaches the filter through `SYNC_STAGES` flip-flops. The filtered level follows only after the new level has been seen on `DEB_CYCLES` consecutive cycles. A shorter pulse, in either direction, has no effect. This applies to both switch inputs.
- R4: In idle, once the power-on hold has expired and the filtered interval switch is closed (high), `relay_on` rises on the next cycle.
- R5: A sweep ends on the cycle after the filtered park contact, having left `PARK_LEVEL` (default 1), reads `PARK_LEVEL` again. Until then, `relay_on` stays high.
- R6: Opening the interval switch while `relay_on` is high does not drop `relay_on` before the sweep ends.
- R7: If the filtered interval switch is closed at the end of a sweep and `pause_ticks` holds N > 0, the behaviour is as follows. The value of `pause_ticks` is captured at that moment. `relay_on` is low and `slow_sel` is high for exactly N cycles. Then `slow_sel` falls and `relay_on` rises on the same cycle.
- R8: If `pause_ticks` is zero at the end of a sweep and the interval switch is closed, `relay_on` stays high into the next sweep and `slow_sel` never rises.
- R9: If the filtered interval switch is open at the end of a sweep, the block returns to idle: `relay_on` and `slow_sel` are low, and no new sweep starts until the switch closes again.
- R10: If the filtered interval switch opens during a pause, the pause is abandoned. On the next cycle both outputs are low.
- R11: `relay_on` and `slow_sel` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (base or interval oscillator) |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_raw | input | 1 | Raw interval selector switch, high = closed |
| park_raw | input | 1 | Raw park contact |
| pause_ticks | input | PAUSE_W | Pause length in clock ticks |
| relay_on | output | 1 | Relay drive request |
| slow_sel | output | 1 | High while the interval pause runs, selects the slow oscillator rate |

## Verification
The bench builds the block with `DEB_CYCLES` = 3, `SYNC_STAGES` = 2, `POR_CYCLES` = 6 and `PAUSE_W` = 6. These short values let a two-cycle glitch sit just under the filter threshold, and they let the power-on hold and several full sweep-and-pause rounds fit in a few hundred cycles. A six-bit pause input allows pauses of 0, 4 and 8 ticks. That covers the skip-pause path, an exact pause-length count, and an abandoned pause. A behavioural model of the filters and the sweep sequence is stepped in the bench and compared with both outputs on every cycle.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
   typedef enum logic [1:0] {
      WS_IDLE   = 2'd0,
      WS_LEAVE  = 2'd1,
      WS_RETURN = 2'd2,
      WS_PAUSE  = 2'd3
   } wiper_st_e;
endpackage

// File: rtl/wiper_debounce.sv
module wiper_debounce #(
   parameter int   DEB_CYCLES  = 4,
   parameter int   SYNC_STAGES = 2,
   parameter logic RST_VAL     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic q
);
   localparam int CW = $clog2(DEB_CYCLES + 1);

   if (DEB_CYCLES < 1) begin : g_bad_deb
      $error("DEB_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic s_in;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign s_in = raw;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= {SYNC_STAGES{RST_VAL}};
         end else begin
            chain[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign s_in = chain[SYNC_STAGES-1];
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= RST_VAL;
         cnt <= '0;
      end else if (s_in == q) begin
         cnt <= '0;
      end else if (cnt == CW'(DEB_CYCLES - 1)) begin
         q   <= s_in;
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R3: the filtered level only ever moves to the sampled level
   a_r3_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q) |-> (q == $past(s_in)));
   // R3: a mismatch that is still short of the threshold never flips the output
   a_r3_no_early_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (s_in != q && cnt < CW'(DEB_CYCLES - 1)) |=> $stable(q));
endmodule

// File: rtl/wiper_por_hold.sv
module wiper_por_hold #(
   parameter int POR_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int PW = $clog2(POR_CYCLES + 1);

   if (POR_CYCLES < 1) begin : g_bad_por
      $error("POR_CYCLES must be at least 1");
   end

   logic [PW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (cnt != PW'(POR_CYCLES)) cnt <= cnt + 1'b1;
   end

   assign done = (cnt == PW'(POR_CYCLES));

   // R2: once released, the hold stays released until the next reset
   a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
endmodule

// File: rtl/wiper_seq_fsm.sv
module wiper_seq_fsm
   import wiper_pkg::*;
#(
   parameter int   PAUSE_W    = 8,
   parameter logic PARK_LEVEL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               int_d,
   input  logic               park_d,
   input  logic [PAUSE_W-1:0] pause_ticks,
   output logic               relay_on,
   output logic               slow_sel
);
   if (PAUSE_W < 1) begin : g_bad_pw
      $error("PAUSE_W must be at least 1");
   end

   wiper_st_e          st, st_nx;
   logic [PAUSE_W-1:0] len_q, len_nx;
   logic [PAUSE_W-1:0] cnt_q, cnt_nx;
   logic               at_rest;

   assign at_rest = (park_d == PARK_LEVEL);

   always_comb begin
      st_nx  = st;
      len_nx = len_q;
      cnt_nx = cnt_q;
      unique case (st)
         WS_IDLE:   if (en && int_d) st_nx = WS_LEAVE;
         WS_LEAVE:  if (!at_rest) st_nx = WS_RETURN;
         WS_RETURN: begin
            if (at_rest) begin
               if (!int_d) begin
                  st_nx = WS_IDLE;
               end else if (pause_ticks == '0) begin
                  st_nx = WS_LEAVE;
               end else begin
                  st_nx  = WS_PAUSE;
                  len_nx = pause_ticks;
                  cnt_nx = '0;
               end
            end
         end
         WS_PAUSE: begin
            if (!int_d)                       st_nx = WS_IDLE;
            else if (cnt_q == len_q - 1'b1)   st_nx = WS_LEAVE;
            else                              cnt_nx = cnt_q + 1'b1;
         end
         default: st_nx = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= WS_IDLE;
         len_q <= '0;
         cnt_q <= '0;
      end else begin
         st    <= st_nx;
         len_q <= len_nx;
         cnt_q <= cnt_nx;
      end
   end

   assign relay_on = en && (st == WS_LEAVE || st == WS_RETURN);
   assign slow_sel = (st == WS_PAUSE);

   // R6: a sweep in progress with the contact away from rest keeps the relay on
   a_r6_sweep_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WS_RETURN && !at_rest) |=> relay_on);
   // R9: sweep end with the switch open goes quiet
   a_r9_quiet_on_open: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WS_RETURN && at_rest && !int_d) |=> (!relay_on && !slow_sel));
   // R8: zero pause chains straight into the next sweep
   a_r8_zero_pause: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WS_RETURN && at_rest && int_d && pause_ticks == '0) |=> (relay_on && !slow_sel));
   // R7: a pause not yet at its length keeps running
   a_r7_pause_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_sel && int_d && cnt_q != len_q - 1'b1) |=> slow_sel);
   // R10: opening the switch abandons the pause
   a_r10_pause_abandon: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_sel && !int_d) |=> (!slow_sel && !relay_on));
endmodule

// File: rtl/wiper_interval_seq.sv
module wiper_interval_seq #(
   parameter int   DEB_CYCLES  = 4,
   parameter int   SYNC_STAGES = 2,
   parameter int   POR_CYCLES  = 16,
   parameter int   PAUSE_W     = 8,
   parameter logic PARK_LEVEL  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               int_raw,
   input  logic               park_raw,
   input  logic [PAUSE_W-1:0] pause_ticks,
   output logic               relay_on,
   output logic               slow_sel
);
   localparam int   NCH = 2;
   localparam logic INT_RST  = 1'b0;

   logic [NCH-1:0] raw_v, deb_v;
   logic           por_done;

   assign raw_v = {park_raw, int_raw};

   for (genvar c = 0; c < NCH; c++) begin : g_deb
      wiper_debounce #(
         .DEB_CYCLES (DEB_CYCLES),
         .SYNC_STAGES(SYNC_STAGES),
         .RST_VAL    ((c == 0) ? INT_RST : PARK_LEVEL)
      ) u_deb (
         .clk  (clk),
         .rst_n(rst_n),
         .raw  (raw_v[c]),
         .q    (deb_v[c])
      );
   end

   wiper_por_hold #(.POR_CYCLES(POR_CYCLES)) u_por (
      .clk  (clk),
      .rst_n(rst_n),
      .done (por_done)
   );

   wiper_seq_fsm #(.PAUSE_W(PAUSE_W), .PARK_LEVEL(PARK_LEVEL)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (por_done),
      .int_d      (deb_v[0]),
      .park_d     (deb_v[1]),
      .pause_ticks(pause_ticks),
      .relay_on   (relay_on),
      .slow_sel   (slow_sel)
   );

   // R2: relay held off during the power-on hold
   a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      !por_done |-> !relay_on);
   // R11: outputs mutually exclusive
   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(relay_on && slow_sel));
endmodule

// File: tb/wiper_interval_seq_test.sv
module wiper_interval_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEB  = 3;
   localparam int SYNC = 2;
   localparam int POR  = 6;
   localparam int PW   = 6;
   localparam int WATCHDOG = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          int_raw = 1'b0;
   logic          park_raw = 1'b1;
   logic [PW-1:0] pause_ticks = '0;
   logic          relay_on, slow_sel;

   always #(CLK_PERIOD/2) clk = ~clk;

   wiper_interval_seq #(
      .DEB_CYCLES(DEB), .SYNC_STAGES(SYNC), .POR_CYCLES(POR),
      .PAUSE_W(PW), .PARK_LEVEL(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .int_raw(int_raw), .park_raw(park_raw),
      .pause_ticks(pause_ticks), .relay_on(relay_on), .slow_sel(slow_sel)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   task automatic chk(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_st, m_cnt, m_len, m_por;
   bit m_q[2];
   int m_dc[2];
   bit m_sy[2][SYNC];
   int nst;
   bit sin;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_len = 0; m_por = 0;
         m_q[0] = 0; m_q[1] = 1; m_dc[0] = 0; m_dc[1] = 0;
         for (int i = 0; i < SYNC; i++) begin m_sy[0][i] = 0; m_sy[1][i] = 1; end
      end else begin
         nst = m_st;
         case (m_st)
            0: if (m_por == POR && m_q[0]) nst = 1;
            1: if (m_q[1] != 1) nst = 2;
            2: if (m_q[1] == 1) begin
                  if (!m_q[0]) nst = 0;
                  else if (pause_ticks == 0) nst = 1;
                  else begin nst = 3; m_len = pause_ticks; m_cnt = 0; end
               end
            default: begin
               if (!m_q[0]) nst = 0;
               else if (m_cnt == m_len - 1) nst = 1;
               else m_cnt++;
            end
         endcase
         m_st = nst;
         if (m_por < POR) m_por++;
         for (int c = 0; c < 2; c++) begin
            sin = m_sy[c][SYNC-1];
            if (sin == m_q[c]) m_dc[c] = 0;
            else if (m_dc[c] == DEB - 1) begin m_q[c] = sin; m_dc[c] = 0; end
            else m_dc[c]++;
         end
         for (int i = SYNC - 1; i > 0; i--) begin
            m_sy[0][i] = m_sy[0][i-1];
            m_sy[1][i] = m_sy[1][i-1];
         end
         m_sy[0][0] = int_raw;
         m_sy[1][0] = park_raw;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R5 relay vs model", relay_on, ((m_st == 1 || m_st == 2) && m_por == POR));
         chk("R7 slow_sel vs model", slow_sel, (m_st == 3));
         chk("R11 exclusive", relay_on && slow_sel, 1'b0);
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_for(ref logic sig, input logic val, input int lim, input string req);
      int k = 0;
      while (sig !== val && k < lim) begin @(negedge clk); k++; end
      chk(req, sig, val);
   endtask

   task automatic sweep(int away);
      park_raw = 1'b0;
      step(away);
      park_raw = 1'b1;
   endtask

   int cnt;

   initial begin
      // R1 reset state
      step(4);
      chk("R1 relay in reset", relay_on, 1'b0);
      chk("R1 slow in reset", slow_sel, 1'b0);
      int_raw = 1'b1;
      rst_n = 1'b1;
      step(1);
      chk("R1 relay after release", relay_on, 1'b0);
      chk("R1 slow after release", slow_sel, 1'b0);
      // R2 hold off although the switch is closed
      for (int i = 0; i < POR - 1; i++) begin
         chk("R2 relay held", relay_on, 1'b0);
         step(1);
      end
      // R4 start after hold
      wait_for(relay_on, 1'b1, 20, "R4 relay starts");

      // R7 pause of 4 ticks
      pause_ticks = 6'd4;
      step(2);
      sweep(6);
      wait_for(slow_sel, 1'b1, 20, "R7 pause entered");
      cnt = 0;
      while (slow_sel === 1'b1 && cnt < 50) begin
         chk("R7 relay low in pause", relay_on, 1'b0);
         cnt++; step(1);
      end
      total++;
      if (cnt != 4) begin bad++; $display("FAIL R7 pause length actual=%0d expected=%0d", cnt, 4); end
      chk("R7 relay after pause", relay_on, 1'b1);

      // R6 open during sweep, R9 idle afterwards
      step(2);
      park_raw = 1'b0;
      step(6);
      int_raw = 1'b0;
      step(10);
      chk("R6 relay kept on", relay_on, 1'b1);
      park_raw = 1'b1;
      step(10);
      chk("R9 relay off", relay_on, 1'b0);
      chk("R9 slow off", slow_sel, 1'b0);
      cnt = 0;
      for (int i = 0; i < 20; i++) begin if (relay_on || slow_sel) cnt++; step(1); end
      total++;
      if (cnt != 0) begin bad++; $display("FAIL R9 activity actual=%0d expected=%0d", cnt, 0); end

      // R3 glitch shorter than the filter
      int_raw = 1'b1; step(DEB - 1); int_raw = 1'b0;
      cnt = 0;
      for (int i = 0; i < 15; i++) begin if (relay_on) cnt++; step(1); end
      total++;
      if (cnt != 0) begin bad++; $display("FAIL R3 glitch relay cycles actual=%0d expected=%0d", cnt, 0); end
      // R3 park glitch during a sweep does not end it
      int_raw = 1'b1;
      wait_for(relay_on, 1'b1, 20, "R3 relay after long close");

      // R8 zero pause
      pause_ticks = '0;
      park_raw = 1'b0; step(6);
      park_raw = 1'b1; step(DEB - 1); park_raw = 1'b0;
      step(6);
      chk("R3 park glitch ignored", relay_on, 1'b1);
      park_raw = 1'b1;
      cnt = 0;
      for (int i = 0; i < 15; i++) begin
         if (slow_sel) cnt++;
         chk("R8 relay continuous", relay_on, 1'b1);
         step(1);
      end
      total++;
      if (cnt != 0) begin bad++; $display("FAIL R8 slow cycles actual=%0d expected=%0d", cnt, 0); end

      // R10 open during a pause
      pause_ticks = 6'd40;
      sweep(6);
      wait_for(slow_sel, 1'b1, 20, "R10 pause entered");
      int_raw = 1'b0;
      step(10);
      chk("R10 slow dropped", slow_sel, 1'b0);
      chk("R10 relay off", relay_on, 1'b0);
      step(20);
      chk("R10 still idle", relay_on, 1'b0);

      // R5 second round with an 8 tick pause
      pause_ticks = 6'd8;
      int_raw = 1'b1;
      wait_for(relay_on, 1'b1, 20, "R4 restart");
      sweep(8);
      wait_for(slow_sel, 1'b1, 20, "R5 sweep ended into pause");
      step(20);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule